// File: doc/BRIEF.md
# Prescaled Pulse Counter with Residue Recovery

This block totals a long burst of input pulses that is first divided down by a small external modulo-N prescaler. While an acquisition is open, the block only sees the prescaler's overflow line. It counts each overflow once, and each overflow stands for N input pulses. The prescaler's leftover count is never read directly.

After the acquisition closes, a start request launches recovery of that leftover count. The block drives its own pulses into the prescaler one at a time. It uses a programmable high time and low time, and after every pulse it checks whether an overflow came back. The number of pulses k that were needed tells it the residue left in the prescaler, which is N − k. The exact total is the overflow count × N + (N − k).

The result leaves on a valid/ready output. Back-pressure rule: once valid is raised, the total stays constant and valid stays high until a cycle in which ready is high. Valid drops on the cycle after that handshake. While a result waits, no new recovery can start. If N pulses go in and no overflow comes back, an error flag is raised instead of valid. The next acquisition start clears both the error flag and the overflow count.

Top module: `pulse_tally`

## Requirements
- R1: After reset, inj_o, total_valid_o and err_o are low and total_o is zero.
- R2: Each rising edge of ovf_i that comes outside recovery adds exactly one to the overflow count, however long ovf_i stays high. ovf_i is asynchronous and must stay high for at least 2 clock cycles and low for at least 2 clock cycles.
- R3: A rising edge of acq_i clears the overflow count and err_o on the next cycle.
- R4: A start_i pulse starts recovery only if acq_i is low, no recovery is running and no result is waiting. In every other case it is ignored, and inj_o stays low.
- R5: Each injected pulse holds inj_o high for max(hi_time_i,1) cycles. inj_o then stays low for max(lo_time_i,1)+4 cycles before the next pulse or the final decision. The extra 4 cycles cover the synchronizer and edge-detect latency.
- R6: Recovery stops after the first injected pulse that is followed by an overflow. The result is total_o = overflow_count × N + (N − k), where k is the number of pulses injected. With N = 16 this means a burst of P pulses, starting from an empty prescaler, gives total_o = P and uses 16 − (P mod 16) injected pulses.
- R7: While total_valid_o is high and total_ready_i is low, total_valid_o stays high and total_o stays stable. After a cycle with both high, total_valid_o is low.
- R8: If N pulses are injected without an overflow, err_o is raised and total_valid_o is not. err_o stays high until the next acquisition start.
- R9: inj_o is low whenever no recovery is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_i | input | 1 | High while an acquisition is open |
| ovf_i | input | 1 | Overflow line of the external prescaler (asynchronous) |
| start_i | input | 1 | Single-cycle request to start residue recovery |
| hi_time_i | input | TW (8) | Injected pulse high time in cycles (0 acts as 1) |
| lo_time_i | input | TW (8) | Injected pulse low time in cycles (0 acts as 1) |
| inj_o | output | 1 | Injected pulse to the prescaler input |
| total_o | output | TOT_W (21) | Full-resolution pulse total |
| total_valid_o | output | 1 | Total is valid |
| total_ready_i | input | 1 | Consumer accepts the total |
| err_o | output | 1 | Recovery saw no overflow after N pulses |

## Verification
The hardest case to reach is a prescaler that never overflows, because a correct prescaler always overflows within N pulses. The bench's prescaler model has a stuck mode that ignores every pulse, and this drives the block into its error path. Right after that error, a fresh acquisition shows whether the error flag and the overflow count are cleared. The other corners need deliberate burst lengths: an exact multiple of N forces the full N injected pulses, and a long overflow pulse checks that each overflow is counted only once.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_HIGH   = 2'd1,
    S_LOW    = 2'd2,
    S_SETTLE = 2'd3
  } rec_state_t;
endpackage

// File: rtl/pt_edge_sync.sv
module pt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pt_ovf_counter.sv
module pt_ovf_counter #(
  parameter int W        = 16,
  parameter bit SATURATE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] nxt;

  generate
    if (SATURATE) begin : g_sat
      assign nxt = (cnt_q == {W{1'b1}}) ? cnt_q : cnt_q + 1'b1;
    end else begin : g_wrap
      assign nxt = cnt_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= nxt;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/pt_injector.sv
module pt_injector
  import pt_pkg::*;
#(
  parameter int MOD_N  = 16,
  parameter int TW     = 8,
  parameter int SETTLE = 4,
  parameter int KW     = $clog2(MOD_N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [TW-1:0] hi_i,
  input  logic [TW-1:0] lo_i,
  input  logic          ovf_rise_i,
  output logic          inj_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [KW-1:0] k_o
);
  localparam int SW    = $clog2(SETTLE + 1);
  localparam int TMR_W = (TW > SW) ? TW : SW;

  rec_state_t       state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [KW-1:0]    k_q, k_d;
  logic             seen_q, seen_d;
  logic             inj_q;

  function automatic logic [TMR_W-1:0] ld(input logic [TW-1:0] t);
    return (t == '0) ? '0 : TMR_W'(t - 1'b1);
  endfunction

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    k_d     = k_q;
    seen_d  = seen_q | ((state_q != S_IDLE) & ovf_rise_i);
    done_o  = 1'b0;
    fail_o  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d = S_HIGH;
          tmr_d   = ld(hi_i);
          k_d     = '0;
          seen_d  = 1'b0;
        end
      end
      S_HIGH: begin
        if (tmr_q == '0) begin
          state_d = S_LOW;
          tmr_d   = ld(lo_i);
          k_d     = k_q + 1'b1;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      S_LOW: begin
        if (tmr_q == '0) begin
          state_d = S_SETTLE;
          tmr_d   = TMR_W'(SETTLE - 1);
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      S_SETTLE: begin
        if (tmr_q != '0) begin
          tmr_d = tmr_q - 1'b1;
        end else if (seen_q | ovf_rise_i) begin
          state_d = S_IDLE;
          done_o  = 1'b1;
        end else if (k_q == KW'(MOD_N)) begin
          state_d = S_IDLE;
          fail_o  = 1'b1;
        end else begin
          state_d = S_HIGH;
          tmr_d   = ld(hi_i);
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tmr_q   <= '0;
      k_q     <= '0;
      seen_q  <= 1'b0;
      inj_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      k_q     <= k_d;
      seen_q  <= seen_d;
      inj_q   <= (state_d == S_HIGH);
    end
  end

  assign inj_o  = inj_q;
  assign busy_o = (state_q != S_IDLE);
  assign k_o    = k_q;
endmodule

// File: rtl/pulse_tally.sv
module pulse_tally #(
  parameter int MOD_N       = 16,
  parameter int CNT_W       = 16,
  parameter int TW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int KW          = $clog2(MOD_N + 1),
  parameter int TOT_W       = CNT_W + KW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_i,
  input  logic             ovf_i,
  input  logic             start_i,
  input  logic [TW-1:0]    hi_time_i,
  input  logic [TW-1:0]    lo_time_i,
  output logic             inj_o,
  output logic [TOT_W-1:0] total_o,
  output logic             total_valid_o,
  input  logic             total_ready_i,
  output logic             err_o
);
  localparam int SETTLE = SYNC_STAGES + 2;

  logic             ovf_rise;
  logic             acq_q;
  logic             acq_rise;
  logic [CNT_W-1:0] ovf_cnt;
  logic             busy;
  logic             done;
  logic             fail;
  logic [KW-1:0]    k_cnt;
  logic             start_ok;
  logic             valid_q;
  logic             err_q;
  logic [TOT_W-1:0] total_q;

  pt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ovf_i),
    .rise_o  (ovf_rise)
  );

  assign acq_rise = acq_i & ~acq_q;

  pt_ovf_counter #(.W(CNT_W), .SATURATE(1'b1)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (acq_rise),
    .inc_i   (ovf_rise & ~busy),
    .count_o (ovf_cnt)
  );

  assign start_ok = start_i & ~acq_i & ~busy & ~valid_q;

  pt_injector #(.MOD_N(MOD_N), .TW(TW), .SETTLE(SETTLE), .KW(KW)) u_inj (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_ok),
    .hi_i       (hi_time_i),
    .lo_i       (lo_time_i),
    .ovf_rise_i (ovf_rise),
    .inj_o      (inj_o),
    .busy_o     (busy),
    .done_o     (done),
    .fail_o     (fail),
    .k_o        (k_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acq_q   <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      total_q <= '0;
    end else begin
      acq_q <= acq_i;
      if (done) begin
        valid_q <= 1'b1;
        total_q <= TOT_W'(ovf_cnt) * TOT_W'(MOD_N)
                   + TOT_W'(MOD_N) - TOT_W'(k_cnt);
      end else if (valid_q && total_ready_i) begin
        valid_q <= 1'b0;
      end
      if (acq_rise)  err_q <= 1'b0;
      else if (fail) err_q <= 1'b1;
    end
  end

  assign total_o       = total_q;
  assign total_valid_o = valid_q;
  assign err_o         = err_q;
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
  parameter int MOD_N = 16,
  parameter int CNT_W = 16,
  parameter int KW    = 5,
  parameter int TOT_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acq_i,
  input logic             inj_o,
  input logic [TOT_W-1:0] total_o,
  input logic             total_valid_o,
  input logic             total_ready_i,
  input logic             err_o,
  input logic [CNT_W-1:0] ovf_cnt,
  input logic [KW-1:0]    k_cnt,
  input logic             busy
);
  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    total_valid_o && !total_ready_i |=> total_valid_o && $stable(total_o));

  // R7
  valid_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    total_valid_o && total_ready_i |=> !total_valid_o);

  // R3
  acq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_i) |=> (ovf_cnt == '0) && !err_o);

  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !total_valid_o);

  // R8
  k_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    k_cnt <= KW'(MOD_N));

  // R9
  inj_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_o |-> busy);

  // R4
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(acq_i) && !$past(total_valid_o));
endmodule

bind pulse_tally pt_checker #(
  .MOD_N(MOD_N), .CNT_W(CNT_W), .KW(KW), .TOT_W(TOT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .acq_i         (acq_i),
  .inj_o         (inj_o),
  .total_o       (total_o),
  .total_valid_o (total_valid_o),
  .total_ready_i (total_ready_i),
  .err_o         (err_o),
  .ovf_cnt       (ovf_cnt),
  .k_cnt         (k_cnt),
  .busy          (busy)
);

// File: tb/tb_pulse_tally.sv
module tb_pulse_tally;
  localparam int N     = 16;
  localparam int TW    = 8;
  localparam int TOT_W = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq_i = 1'b0;
  logic ovf_i;
  logic start_i = 1'b0;
  logic [TW-1:0] hi_time_i = 8'd1;
  logic [TW-1:0] lo_time_i = 8'd1;
  logic inj_o;
  logic [TOT_W-1:0] total_o;
  logic total_valid_o;
  logic total_ready_i = 1'b0;
  logic err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pulse_tally dut (
    .clk(clk), .rst_n(rst_n), .acq_i(acq_i), .ovf_i(ovf_i),
    .start_i(start_i), .hi_time_i(hi_time_i), .lo_time_i(lo_time_i),
    .inj_o(inj_o), .total_o(total_o), .total_valid_o(total_valid_o),
    .total_ready_i(total_ready_i), .err_o(err_o)
  );

  // prescaler model: modulo-N, overflow pulse of ovf_width cycles
  logic ext_pulse = 1'b0;
  logic ext_q = 1'b0;
  logic inj_q = 1'b0;
  bit   stuck = 0;
  int   ovf_width = 3;
  int   pre_cnt = 0;
  int   ovf_tmr = 0;

  always @(posedge clk) begin
    ext_q <= ext_pulse;
    inj_q <= inj_o;
    if (((ext_pulse && !ext_q) || (inj_o && !inj_q)) && !stuck) begin
      if (pre_cnt == N - 1) begin
        pre_cnt <= 0;
        ovf_tmr <= ovf_width;
      end else begin
        pre_cnt <= pre_cnt + 1;
        if (ovf_tmr != 0) ovf_tmr <= ovf_tmr - 1;
      end
    end else if (ovf_tmr != 0) begin
      ovf_tmr <= ovf_tmr - 1;
    end
  end
  assign ovf_i = (ovf_tmr != 0);

  // injected pulse monitor
  logic inj_prev = 1'b0;
  int inj_rises = 0;
  int hi_run = 0, last_hi = 0, lo_run = 0, last_gap = 0;
  always @(posedge clk) begin
    inj_prev <= inj_o;
    if (inj_o) begin
      hi_run <= inj_prev ? hi_run + 1 : 1;
      if (!inj_prev) begin
        inj_rises <= inj_rises + 1;
        last_gap  <= lo_run;
      end
    end else begin
      if (inj_prev) begin
        last_hi <= hi_run;
        lo_run  <= 1;
      end else begin
        lo_run <= lo_run + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic acquire(input int pulses, input int width);
    @(negedge clk);
    ovf_width = width;
    acq_i = 1'b1;
    @(negedge clk);
    for (int i = 0; i < pulses; i++) begin
      ext_pulse = 1'b1;
      @(negedge clk);
      ext_pulse = 1'b0;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    acq_i = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  task automatic wait_end();
    for (int i = 0; i < 5000; i++) begin
      if (total_valid_o || err_o) break;
      @(negedge clk);
    end
  endtask

  task automatic accept();
    total_ready_i = 1'b1;
    @(negedge clk);
    total_ready_i = 1'b0;
    chk(!total_valid_o, "R7 valid clears after handshake", total_valid_o, 0);
  endtask

  task automatic recover(input int hi, input int lo, input int exp_total, input string tag);
    int base;
    int exp_k;
    base = inj_rises;
    exp_k = N - (exp_total % N);
    @(negedge clk);
    hi_time_i = TW'(hi);
    lo_time_i = TW'(lo);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_end();
    chk(total_valid_o && !err_o, {tag, " R6 valid raised"}, total_valid_o, 1);
    chk(total_o == TOT_W'(exp_total), {tag, " R6 total"}, total_o, exp_total);
    chk(inj_rises - base == exp_k, {tag, " R6 injected count"}, inj_rises - base, exp_k);
    chk(last_hi == ((hi == 0) ? 1 : hi), {tag, " R5 high time"}, last_hi, (hi == 0) ? 1 : hi);
    if (exp_k > 1)
      chk(last_gap == ((lo == 0) ? 1 : lo) + 4, {tag, " R5 low gap"}, last_gap, ((lo == 0) ? 1 : lo) + 4);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!inj_o, "R1 inj_o after reset", inj_o, 0);
    chk(!total_valid_o, "R1 valid after reset", total_valid_o, 0);
    chk(!err_o, "R1 err after reset", err_o, 0);
    chk(total_o == '0, "R1 total after reset", total_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_basic();
    acquire(37, 3);
    recover(2, 1, 37, "A");
    accept();
    // R2: long overflow pulses, exact multiple of N needs all N injections
    acquire(48, 8);
    recover(0, 3, 48, "B");
    accept();
    acquire(0, 3);
    recover(1, 1, 0, "C");
    accept();
    acquire(200, 2);
    recover(1, 2, 200, "D R2");
    accept();
  endtask

  task automatic t_backpressure();
    int base;
    logic [TOT_W-1:0] held;
    acquire(7, 3);
    recover(3, 2, 7, "BP");
    held = total_o;
    base = inj_rises;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (40) @(negedge clk);
    chk(total_valid_o, "R7 valid held without ready", total_valid_o, 1);
    chk(total_o == held, "R7 total stable without ready", total_o, held);
    chk(inj_rises == base && !inj_o, "R4 start ignored while result waits", inj_rises - base, 0);
    accept();
  endtask

  task automatic t_start_during_acq();
    int base;
    base = inj_rises;
    @(negedge clk);
    acq_i = 1'b1;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (30) @(negedge clk);
    chk(inj_rises == base, "R4 start ignored during acquisition", inj_rises - base, 0);
    chk(!inj_o, "R9 inj_o low outside recovery", inj_o, 0);
    acq_i = 1'b0;
    repeat (4) @(negedge clk);
    acquire(3, 3);
    recover(2, 2, 3, "E");
    accept();
  endtask

  task automatic t_error();
    int base;
    stuck = 1;
    acquire(5, 3);
    base = inj_rises;
    @(negedge clk);
    hi_time_i = 8'd1;
    lo_time_i = 8'd1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_end();
    chk(err_o, "R8 error raised", err_o, 1);
    chk(!total_valid_o, "R8 no valid on error", total_valid_o, 0);
    chk(inj_rises - base == N, "R8 N pulses before error", inj_rises - base, N);
    repeat (10) @(negedge clk);
    chk(err_o, "R8 error held", err_o, 1);
    stuck = 0;
    @(negedge clk);
    acq_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!err_o, "R3 error cleared by acquisition start", err_o, 1'b0);
    acq_i = 1'b0;
    repeat (4) @(negedge clk);
    // R3: result reflects only the new burst
    acquire(20, 3);
    recover(1, 1, 20, "G R3");
    accept();
  endtask

  initial begin
    t_reset();
    t_basic();
    t_backpressure();
    t_start_during_acq();
    t_error();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule